// File: doc/BRIEF.md
# Nested Priority Interrupt Arbiter

This block chooses which of a set of interrupt request lines may interrupt a single processor. Each source has a programmable priority, a mask bit, and a sense bit that selects live level tracking or rising-edge latching. A task priority input sets a floor that a request must beat. The block also keeps a bitmap of the sources now in service, so one service routine can be interrupted by another, and it drives one interrupt output.

When the processor pulses the acknowledge input, the block returns the vector of the winning source one cycle later and marks that source in service. It records the priority level the source had at that moment. If no source qualifies at that moment, the block returns a programmable spurious vector and changes no state. An end-of-interrupt pulse retires the in-service entry with the highest recorded level. A new request must beat that level, and the task priority as well, before it can raise the interrupt. So lowering the task priority inside a handler cannot let a weaker request cut in.

Top module: `nested_irq_arbiter`

## Requirements
- R1: After reset, int_o, ack_valid_o and every in_service_o bit are 0.
- R2: int_o is high exactly when the best unmasked pending priority is strictly greater than both task_prio_i and the highest in-service level. A source with priority 0 never raises int_o. The output follows its inputs in the same cycle.
- R3: If pending sources share the best priority, the one with the lowest index wins.
- R4: An acknowledge taken while int_o is high has three effects one clock later: ack_valid_o is high, ack_vec_o holds the winning source index zero-extended, and that source's in_service_o bit is set.
- R5: A request at or below the highest in-service level does not raise int_o, even after task_prio_i is lowered. A strictly higher request does raise it.
- R6: Each end-of-interrupt pulse clears only the in-service bit with the highest recorded level. Successive pulses clear the entries in descending level order.
- R7: An acknowledge taken while int_o is low returns spur_vec_i on ack_vec_o, with ack_valid_o high, and leaves in_service_o unchanged. This covers a source that was masked, a level source that was dropped, and a source that a raised task priority has disqualified.
- R8: If the source that raised int_o was masked or dropped before the acknowledge, but another pending source still qualifies, the acknowledge returns that other source's vector rather than the spurious vector.
- R9: sense_i bit = 1 selects level: the line is pending while high, and an acknowledge does not clear it. Bit = 0 selects edge: a rising edge latches a pending bit that stays set after the line falls, and the acknowledge of that source clears it.
- R10: A source whose mask_i bit is 1 is ignored for int_o and for acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NSRC | Request lines, one per source |
| sense_i | input | NSRC | 1 = level, 0 = rising edge |
| mask_i | input | NSRC | 1 = source masked |
| prio_i | input | NSRC*PW | Priority of source i in bits [i*PW +: PW] |
| task_prio_i | input | PW | Current task priority |
| spur_vec_i | input | VW | Vector returned when no source qualifies |
| ack_i | input | 1 | Acknowledge pulse |
| eoi_i | input | 1 | End-of-interrupt pulse |
| int_o | output | 1 | Interrupt request to the processor |
| ack_valid_o | output | 1 | ack_vec_o is valid this cycle |
| ack_vec_o | output | VW | Acknowledged vector |
| in_service_o | output | NSRC | In-service bitmap |

## Verification
The bench uses the default values: 16 sources, 4-bit priorities and 8-bit vectors. With 16 sources, equal priorities can be placed at widely separated indices to test tie-breaking. The 16 priority levels leave room to stack several in-service entries with task priorities below, between and above them. The spurious vector 8'hFF cannot be confused with any source index, and the bench mixes level and edge sources in the same runs.

// File: rtl/nested_irq_arbiter.sv
module nested_irq_arbiter #(
  parameter int NSRC = 16,
  parameter int PW   = 4,
  parameter int VW   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   req_i,
  input  logic [NSRC-1:0]   sense_i,
  input  logic [NSRC-1:0]   mask_i,
  input  logic [NSRC*PW-1:0] prio_i,
  input  logic [PW-1:0]     task_prio_i,
  input  logic [VW-1:0]     spur_vec_i,
  input  logic              ack_i,
  input  logic              eoi_i,
  output logic              int_o,
  output logic              ack_valid_o,
  output logic [VW-1:0]     ack_vec_o,
  output logic [NSRC-1:0]   in_service_o
);
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [NSRC-1:0] req_q, edge_pend, live;
  logic [PW-1:0]   isr_lvl [NSRC];
  logic [PW-1:0]   best_p, top_p;
  logic [IW-1:0]   best_i, top_i;
  logic            take, retire;

  assign live = ((sense_i & req_i) | (~sense_i & edge_pend)) & ~mask_i;

  always_comb begin
    best_p = '0;
    best_i = '0;
    for (int i = 0; i < NSRC; i++)
      if (live[i] && prio_i[i*PW +: PW] > best_p) begin
        best_p = prio_i[i*PW +: PW];
        best_i = IW'(i);
      end
  end

  always_comb begin
    top_p = '0;
    top_i = '0;
    for (int i = 0; i < NSRC; i++)
      if (in_service_o[i] && isr_lvl[i] > top_p) begin
        top_p = isr_lvl[i];
        top_i = IW'(i);
      end
  end

  assign int_o  = (best_p > task_prio_i) && (best_p > top_p);
  assign take   = ack_i && int_o;
  assign retire = eoi_i && (|in_service_o);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q        <= '0;
      edge_pend    <= '0;
      in_service_o <= '0;
      ack_valid_o  <= 1'b0;
      ack_vec_o    <= '0;
      for (int i = 0; i < NSRC; i++) isr_lvl[i] <= '0;
    end else begin
      req_q       <= req_i;
      ack_valid_o <= ack_i;
      if (ack_i) ack_vec_o <= take ? VW'(best_i) : spur_vec_i;
      for (int i = 0; i < NSRC; i++) begin
        if (take && best_i == IW'(i)) begin
          in_service_o[i] <= 1'b1;
          isr_lvl[i]      <= best_p;
        end else if (retire && top_i == IW'(i)) begin
          in_service_o[i] <= 1'b0;
        end
        if (!sense_i[i] && req_i[i] && !req_q[i])
          edge_pend[i] <= 1'b1;
        else if ((take && best_i == IW'(i)) || sense_i[i])
          edge_pend[i] <= 1'b0;
      end
    end
  end

  a_r4_valid_follows_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> ack_valid_o);

  a_r4_ack_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && int_o && !eoi_i) |=>
      $countones(in_service_o) == $countones($past(in_service_o)) + 1);

  a_r6_eoi_removes_one: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_i && !ack_i && |in_service_o) |=>
      $countones(in_service_o) + 1 == $countones($past(in_service_o)));

  a_r7_spurious_keeps_isr: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !int_o && !eoi_i) |=> $stable(in_service_o));

  a_r7_spurious_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !int_o) |=> ack_vec_o == $past(spur_vec_i));
endmodule

// File: tb/tb_nested_irq_arbiter.sv
module tb_nested_irq_arbiter;
  localparam int NSRC = 16, PW = 4, VW = 8;

  logic clk = 0, rst_n = 0;
  logic [NSRC-1:0] req_i = '0, sense_i = '1, mask_i = '0;
  logic [NSRC*PW-1:0] prio_i = '0;
  logic [PW-1:0] task_prio_i = '0;
  logic [VW-1:0] spur_vec_i = 8'hFF;
  logic ack_i = 0, eoi_i = 0;
  logic int_o, ack_valid_o;
  logic [VW-1:0] ack_vec_o;
  logic [NSRC-1:0] in_service_o;

  int checks = 0, failures = 0;
  logic [VW-1:0] expq[$];
  string tagq[$];

  always #5 clk = ~clk;

  nested_irq_arbiter #(.NSRC(NSRC), .PW(PW), .VW(VW)) dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .sense_i(sense_i), .mask_i(mask_i),
    .prio_i(prio_i), .task_prio_i(task_prio_i), .spur_vec_i(spur_vec_i),
    .ack_i(ack_i), .eoi_i(eoi_i), .int_o(int_o), .ack_valid_o(ack_valid_o),
    .ack_vec_o(ack_vec_o), .in_service_o(in_service_o));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_prio(int s, logic [PW-1:0] p);
    prio_i[s*PW +: PW] = p;
  endtask

  task automatic settle();
    @(negedge clk);
    #2;
  endtask

  task automatic do_ack(logic [VW-1:0] exp, string tag);
    @(negedge clk);
    expq.push_back(exp);
    tagq.push_back(tag);
    ack_i = 1;
    @(negedge clk);
    ack_i = 0;
    #2;
  endtask

  task automatic do_eoi();
    @(negedge clk);
    eoi_i = 1;
    @(negedge clk);
    eoi_i = 0;
    #2;
  endtask

  always @(negedge clk) begin
    if (ack_valid_o) begin
      checks++;
      if (expq.size() == 0) begin
        failures++;
        $display("FAIL R4 unexpected ack actual=%0h expected=none", ack_vec_o);
      end else begin
        automatic logic [VW-1:0] e = expq.pop_front();
        automatic string t = tagq.pop_front();
        if (ack_vec_o !== e) begin
          failures++;
          $display("FAIL %s ack vector actual=%0h expected=%0h", t, ack_vec_o, e);
        end
      end
    end
  end

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    check("R1 int", int_o, 0);
    check("R1 valid", ack_valid_o, 0);
    check("R1 isr", in_service_o, 0);
    rst_n = 1;

    // R2 level source against task priority
    set_prio(3, 5); req_i[3] = 1; #2;
    check("R2 int on", int_o, 1);
    task_prio_i = 5; #2;
    check("R2 equal task blocks", int_o, 0);
    task_prio_i = 4; #2;
    check("R2 lower task passes", int_o, 1);
    task_prio_i = 0;

    // R3 tie, R4 ack
    set_prio(7, 5); req_i[7] = 1;
    do_ack(8'd3, "R3 R4 tie lowest index");
    check("R4 isr bit", in_service_o, 16'h0008);
    check("R5 equal not preempt", int_o, 0);

    // R5 lowering task does not admit lower request
    set_prio(10, 4); req_i[10] = 1; task_prio_i = 0; #2;
    check("R5 lower blocked", int_o, 0);
    req_i[10] = 0;
    set_prio(9, 9); req_i[9] = 1; #2;
    check("R5 higher preempts", int_o, 1);
    do_ack(8'd9, "R5 nested ack");
    check("R5 nested isr", in_service_o, 16'h0208);
    req_i[9] = 0;

    // R6 retire descending
    do_eoi();
    check("R6 first eoi", in_service_o, 16'h0008);
    check("R6 still blocked", int_o, 0);
    do_eoi();
    check("R6 second eoi", in_service_o, 16'h0000);
    check("R9 level kept after ack", int_o, 1);
    req_i[3] = 0; req_i[7] = 0; #2;
    check("R9 level dropped", int_o, 0);

    // R7 spurious cases
    do_ack(8'hFF, "R7 no int");
    check("R7 isr unchanged", in_service_o, 0);
    set_prio(2, 4); req_i[2] = 1; #2;
    check("R2 pending", int_o, 1);
    mask_i[2] = 1; #2;
    check("R10 masked", int_o, 0);
    do_ack(8'hFF, "R7 R10 masked ack");
    check("R7 masked isr", in_service_o, 0);
    mask_i[2] = 0; task_prio_i = 6; #2;
    do_ack(8'hFF, "R7 task raised");
    check("R7 task isr", in_service_o, 0);
    task_prio_i = 0;

    // R8 other source qualifies
    set_prio(5, 3); req_i[5] = 1; mask_i[2] = 1; #2;
    do_ack(8'd5, "R8 alternate source");
    check("R8 isr", in_service_o, 16'h0020);
    do_eoi();
    req_i = '0; mask_i = '0; #2;

    // R9 edge source
    sense_i[12] = 0; set_prio(12, 6);
    @(negedge clk); req_i[12] = 1;
    @(negedge clk); req_i[12] = 0; #2;
    check("R9 edge latched", int_o, 1);
    do_ack(8'd12, "R9 edge ack");
    check("R9 edge isr", in_service_o, 16'h1000);
    do_eoi();
    check("R9 edge cleared", int_o, 0);

    // R2 priority zero never interrupts
    set_prio(1, 0); req_i[1] = 1; #2;
    check("R2 prio zero", int_o, 0);
    req_i[1] = 0;

    settle();
    check("R4 queue drained", expq.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule